// File: doc/BRIEF.md
# Successive-Approximation ADC Control and Status Block

This block sits on a small 8-bit peripheral bus and runs an 8-bit successive-approximation conversion against an external comparator. Software reaches it through two locations: a control/status register, and a result register that can only be read. A write that sets the start bit with the power bit high begins a conversion. The block first spends one step in a sample phase. It then resolves the code from the most significant bit down to the least, one bit per `step_tick`. It holds each trial code on `dac_code` and keeps a bit when the comparator reports the input at or above that trial code.

When the last bit is resolved, the result register is loaded and the end-of-conversion flag is raised. Software cannot clear that flag. Only a new start clears it. The interrupt request is asserted while the flag and the interrupt enable are both high, so software silences it by clearing the enable. A start written during a conversion abandons that conversion and begins again from the sample phase. Clearing the power bit also abandons a running conversion, and in that case the flag stays low. The main-oscillator disable bit is only stored here and driven out on a pin.

Top module: `adc_sar_ctrl`

## Requirements
- R1: After reset the control register reads 0x40 (only end-of-conversion set), the result register reads 0x00, and `irq`, `pwr_en` and `osc_off` are low.
- R2: The control register at offset 1 reads as follows: bit 7 is the interrupt enable, bit 6 is end-of-conversion, bit 5 is start, bit 4 is the power bit and bit 2 is the oscillator disable. Start and the reserved bits 3, 1 and 0 always read 0.
- R3: A start accepted with power on produces end-of-conversion exactly on the ninth `step_tick` (one sample step plus 8 bit steps). The result then equals the input code, resolved MSB first. A bit is kept when `cmp_in` is 1, which means the input is at or above the trial code.
- R4: An accepted start clears end-of-conversion. Writing 0 to bit 6 has no effect on it.
- R5: Writing the control register with start at 0 begins no conversion. End-of-conversion and the result stay unchanged whatever ticks follow.
- R6: Writing start as 1 during a conversion abandons it. The new conversion starts from the sample step and completes nine ticks after the rewrite, with the new input code.
- R7: `irq` is high exactly when end-of-conversion and the interrupt enable are both 1. Clearing the enable drops it on the next cycle.
- R8: `pwr_en` follows the power bit. A start written with the power bit 0 is ignored and leaves end-of-conversion unchanged.
- R9: Clearing the power bit during a conversion aborts it. End-of-conversion stays 0 and the result is unchanged.
- R10: The result register at offset 0 changes only when a conversion completes. Bus writes to offset 0 are ignored.
- R11: `osc_off` follows control bit 2.
- R12: The sequencer advances only on `step_tick`. Without ticks a started conversion never completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_tick | input | 1 | One-cycle enable that advances the conversion by one step |
| bus_addr | input | ADDR_W | Register offset (0 result, 1 control) |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| cmp_in | input | 1 | Comparator: 1 when analog input is at or above `dac_code` |
| dac_code | output | RES_W | Current trial code for the comparator's reference |
| sample_en | output | 1 | High during the sample step |
| pwr_en | output | 1 | Converter power enable |
| osc_off | output | 1 | Stored oscillator-disable bit |
| irq | output | 1 | End-of-conversion interrupt request |

## Verification
The hardest situations to reach from the ports are a restart in the middle of a conversion and a power-off in the middle of one. In both, the bench has to land a bus write between step ticks while trial bits are only partly resolved. The bench produces ticks one at a time, so it can stop after a known number of steps, write the control register, and then count the further ticks. Its comparator model is a plain compare against a held input code. The bench changes that code between the abandoned conversion and the fresh one, so a result that leaked from the aborted run would show up.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

   // Register offsets: software depends on these locations.
   localparam int unsigned OFS_RESULT = 0;
   localparam int unsigned OFS_CTRL   = 1;

   // Control register bit positions (software-visible layout).
   localparam int unsigned BIT_IE    = 7;
   localparam int unsigned BIT_EOC   = 6;
   localparam int unsigned BIT_START = 5;
   localparam int unsigned BIT_PWR   = 4;
   localparam int unsigned BIT_OSC   = 2;

   localparam logic [1:0] ST_IDLE   = 2'd0;
   localparam logic [1:0] ST_SAMPLE = 2'd1;
   localparam logic [1:0] ST_CONV   = 2'd2;

   typedef logic [1:0] seq_state_t;

endpackage

// File: rtl/adc_sar_regs.sv
module adc_sar_regs
   import adc_sar_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned RES_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  result,
   output logic              ie,
   output logic              eoc,
   output logic              pwr_on,
   output logic              osc_dis,
   output logic              start_req,
   output logic              abort_req
);

   localparam logic [DATA_W-1:0] USED_MASK =
      DATA_W'((1 << BIT_IE) | (1 << BIT_START) | (1 << BIT_PWR) | (1 << BIT_OSC));

   logic              ctrl_sel;
   logic              res_sel;
   logic              ctrl_wr;
   logic [DATA_W-1:0] ctrl_img;
   logic [DATA_W-1:0] res_img;
   logic              unused_wdata;

   assign ctrl_sel  = (bus_addr == ADDR_W'(OFS_CTRL));
   assign res_sel   = (bus_addr == ADDR_W'(OFS_RESULT));
   assign ctrl_wr   = bus_wr && ctrl_sel;
   assign start_req = ctrl_wr && bus_wdata[BIT_START] && bus_wdata[BIT_PWR];
   assign abort_req = ctrl_wr && !bus_wdata[BIT_PWR] && pwr_on;
   assign unused_wdata = ^(bus_wdata & ~USED_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie      <= 1'b0;
         pwr_on  <= 1'b0;
         osc_dis <= 1'b0;
         eoc     <= 1'b1;
      end else begin
         if (ctrl_wr) begin
            ie      <= bus_wdata[BIT_IE];
            pwr_on  <= bus_wdata[BIT_PWR];
            osc_dis <= bus_wdata[BIT_OSC];
         end
         if (start_req) begin
            eoc <= 1'b0;
         end else if (conv_done) begin
            eoc <= 1'b1;
         end
      end
   end

   always_comb begin
      ctrl_img          = '0;
      ctrl_img[BIT_IE]  = ie;
      ctrl_img[BIT_EOC] = eoc;
      ctrl_img[BIT_PWR] = pwr_on;
      ctrl_img[BIT_OSC] = osc_dis;
   end

   generate
      if (RES_W == DATA_W) begin : g_res_full
         assign res_img = result;
      end else begin : g_res_ext
         assign res_img = {{(DATA_W-RES_W){1'b0}}, result};
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (ctrl_sel) begin
            bus_rdata = ctrl_img;
         end else if (res_sel) begin
            bus_rdata = res_img;
         end
      end
   end

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
   import adc_sar_pkg::*;
#(
   parameter int unsigned RES_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_tick,
   input  logic             start_req,
   input  logic             abort_req,
   input  logic             cmp_in,
   output logic [RES_W-1:0] trial,
   output logic [RES_W-1:0] result,
   output logic             sample_en,
   output logic             busy,
   output logic             conv_done
);

   localparam int unsigned IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);
   localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

   seq_state_t       state;
   logic [IDX_W-1:0] idx;
   logic [RES_W-1:0] cur_mask;
   logic [RES_W-1:0] next_mask;
   logic [RES_W-1:0] decided;
   logic             last_bit;

   assign cur_mask  = RES_W'(1) << idx;
   assign next_mask = cur_mask >> 1;
   assign decided   = cmp_in ? trial : (trial & ~cur_mask);
   assign last_bit  = (idx == '0);
   assign sample_en = (state == ST_SAMPLE);
   assign busy      = (state != ST_IDLE);
   assign conv_done = step_tick && (state == ST_CONV) && last_bit
                      && !start_req && !abort_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= IDX_TOP;
         trial  <= '0;
         result <= '0;
      end else if (start_req) begin
         state <= ST_SAMPLE;
         idx   <= IDX_TOP;
         trial <= '0;
      end else if (abort_req) begin
         state <= ST_IDLE;
         idx   <= IDX_TOP;
         trial <= '0;
      end else if (step_tick) begin
         case (state)
            ST_SAMPLE: begin
               state <= ST_CONV;
               idx   <= IDX_TOP;
               trial <= MSB_ONE;
            end
            ST_CONV: begin
               if (last_bit) begin
                  result <= decided;
                  trial  <= decided;
                  state  <= ST_IDLE;
               end else begin
                  trial <= decided | next_mask;
                  idx   <= idx - 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
   import adc_sar_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned RES_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cmp_in,
   output logic [RES_W-1:0]  dac_code,
   output logic              sample_en,
   output logic              pwr_en,
   output logic              osc_off,
   output logic              irq
);

   generate
      if (DATA_W < 8 || RES_W < 2 || RES_W > DATA_W || ADDR_W < 1) begin : g_bad_cfg
         $error("adc_sar_ctrl: need DATA_W>=8, 2<=RES_W<=DATA_W, ADDR_W>=1");
      end
   endgenerate

   logic             ie_w;
   logic             eoc_w;
   logic             start_req_w;
   logic             abort_req_w;
   logic             conv_done_w;
   logic             busy_w;
   logic [RES_W-1:0] result_w;

   adc_sar_regs #(
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W),
      .RES_W (RES_W)
   ) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_rdata(bus_rdata),
      .conv_done(conv_done_w),
      .result   (result_w),
      .ie       (ie_w),
      .eoc      (eoc_w),
      .pwr_on   (pwr_en),
      .osc_dis  (osc_off),
      .start_req(start_req_w),
      .abort_req(abort_req_w)
   );

   adc_sar_seq #(
      .RES_W(RES_W)
   ) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_tick(step_tick),
      .start_req(start_req_w),
      .abort_req(abort_req_w),
      .cmp_in   (cmp_in),
      .trial    (dac_code),
      .result   (result_w),
      .sample_en(sample_en),
      .busy     (busy_w),
      .conv_done(conv_done_w)
   );

   assign irq = ie_w && eoc_w;

endmodule

// File: rtl/adc_sar_ctrl_chk.sv
module adc_sar_ctrl_chk
   import adc_sar_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned RES_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step_tick,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_wr,
   input logic              irq,
   input logic              pwr_en,
   input logic [RES_W-1:0]  dac_code,
   input logic              eoc,
   input logic              busy,
   input logic              start_req,
   input logic              abort_req,
   input logic              conv_done,
   input logic [RES_W-1:0]  result
);

   logic ctrl_wr;
   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));

   p_done_sets_eoc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> eoc);

   p_start_clears_eoc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |=> !eoc);

   p_eoc_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc && !start_req) |=> eoc);

   p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !bus_wdata[BIT_IE]) |=> !irq);

   p_pwr_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (pwr_en == $past(bus_wdata[BIT_PWR])));

   p_idle_unpowered_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |-> !busy);

   p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |=> $stable(result));

   p_no_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_tick && !start_req && !abort_req) |=> $stable(dac_code));

endmodule

bind adc_sar_ctrl adc_sar_ctrl_chk #(
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W),
   .RES_W (RES_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .step_tick(step_tick),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_wr   (bus_wr),
   .irq      (irq),
   .pwr_en   (pwr_en),
   .dac_code (dac_code),
   .eoc      (eoc_w),
   .busy     (busy_w),
   .start_req(start_req_w),
   .abort_req(abort_req_w),
   .conv_done(conv_done_w),
   .result   (result_w)
);

// File: tb/adc_sar_ctrl_tb.sv
module adc_sar_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 4;
   localparam int RES_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              step_tick = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [DATA_W-1:0] bus_rdata;
   logic              cmp_in;
   logic [RES_W-1:0]  dac_code;
   logic              sample_en;
   logic              pwr_en;
   logic              osc_off;
   logic              irq;
   logic [RES_W-1:0]  vin = '0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Comparator model: input at or above trial code.
   assign cmp_in = (vin >= dac_code);

   adc_sar_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RES_W(RES_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .step_tick(step_tick),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
      .dac_code(dac_code), .sample_en(sample_en), .pwr_en(pwr_en),
      .osc_off(osc_off), .irq(irq)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input int addr, input logic [7:0] data);
      @(negedge clk);
      bus_addr = ADDR_W'(addr);
      bus_wdata = data;
      bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int addr, output logic [7:0] data);
      @(negedge clk);
      bus_addr = ADDR_W'(addr);
      bus_rd = 1'b1;
      #1;
      data = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         step_tick = 1'b1;
         @(negedge clk);
         step_tick = 1'b0;
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      bus_read(1, d);  check("R1", "ctrl reset", d, 8'h40);
      bus_read(0, d);  check("R1", "result reset", d, 8'h00);
      check("R1", "irq reset", irq, 1'b0);
      check("R1", "pwr_en reset", pwr_en, 1'b0);
      check("R1", "osc_off reset", osc_off, 1'b0);
   endtask

   task automatic t_layout();
      logic [7:0] d;
      bus_write(1, 8'h9C);
      bus_read(1, d);  check("R2", "ctrl layout", d, 8'hD4);
      check("R11", "osc_off set", osc_off, 1'b1);
      check("R7", "irq with eoc and ie", irq, 1'b1);
      bus_write(1, 8'h10);
      check("R11", "osc_off clear", osc_off, 1'b0);
      check("R7", "irq after ie clear", irq, 1'b0);
   endtask

   task automatic t_no_start();
      logic [7:0] d;
      vin = 8'h77;
      bus_write(1, 8'h10);
      ticks(12);
      bus_read(1, d);  check("R5", "eoc kept w/o start", d, 8'h50);
      bus_read(0, d);  check("R5", "result kept w/o start", d, 8'h00);
   endtask

   task automatic t_convert(input logic [7:0] code, input logic [7:0] prev);
      logic [7:0] d;
      vin = code;
      bus_write(1, 8'h30);
      bus_read(1, d);  check("R4", "start clears eoc", d, 8'h10);
      repeat (20) @(negedge clk);
      bus_read(1, d);  check("R12", "no progress w/o tick", d, 8'h10);
      ticks(8);
      bus_read(1, d);  check("R3", "eoc low after 8 ticks", d, 8'h10);
      bus_read(0, d);  check("R10", "result held mid-conv", d, prev);
      ticks(1);
      bus_read(1, d);  check("R3", "eoc after 9 ticks", d, 8'h50);
      bus_read(0, d);  check("R3", "result code", d, code);
   endtask

   task automatic t_eoc_write();
      logic [7:0] d;
      bus_write(1, 8'h10);
      bus_read(1, d);  check("R4", "write 0 to eoc ignored", d, 8'h50);
      bus_write(0, 8'hEE);
      bus_read(0, d);  check("R10", "result write ignored", d, 8'h5A);
   endtask

   task automatic t_restart();
      logic [7:0] d;
      vin = 8'h11;
      bus_write(1, 8'h30);
      ticks(5);
      vin = 8'hC3;
      bus_write(1, 8'h30);
      bus_read(1, d);  check("R6", "eoc low after restart", d, 8'h10);
      ticks(8);
      bus_read(1, d);  check("R6", "not done 8 ticks after restart", d, 8'h10);
      ticks(1);
      bus_read(1, d);  check("R6", "done 9 ticks after restart", d, 8'h50);
      bus_read(0, d);  check("R6", "restart result", d, 8'hC3);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      vin = 8'h3C;
      bus_write(1, 8'hB0);
      check("R7", "irq low while converting", irq, 1'b0);
      ticks(9);
      check("R7", "irq on completion", irq, 1'b1);
      bus_write(1, 8'h10);
      check("R7", "irq silenced", irq, 1'b0);
      bus_read(1, d);  check("R7", "eoc kept after silence", d, 8'h50);
   endtask

   task automatic t_unpowered();
      logic [7:0] d;
      bus_write(1, 8'h20);
      check("R8", "pwr_en low", pwr_en, 1'b0);
      bus_read(1, d);  check("R8", "unpowered start ignored", d, 8'h40);
      ticks(12);
      bus_read(1, d);  check("R8", "eoc unchanged", d, 8'h40);
      bus_read(0, d);  check("R8", "result unchanged", d, 8'h3C);
   endtask

   task automatic t_abort();
      logic [7:0] d;
      vin = 8'h99;
      bus_write(1, 8'h30);
      check("R8", "pwr_en high", pwr_en, 1'b1);
      ticks(4);
      bus_write(1, 8'h00);
      ticks(12);
      bus_read(1, d);  check("R9", "abort keeps eoc low", d, 8'h00);
      bus_write(1, 8'h10);
      ticks(12);
      bus_read(1, d);  check("R9", "no resume after abort", d, 8'h10);
      bus_read(0, d);  check("R9", "result unchanged on abort", d, 8'h3C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_layout();
      t_no_start();
      t_convert(8'hA5, 8'h00);
      t_convert(8'h00, 8'hA5);
      t_convert(8'hFF, 8'h00);
      t_convert(8'h5A, 8'hFF);
      t_eoc_write();
      t_restart();
      t_irq();
      t_unpowered();
      t_abort();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule